// File: doc/BRIEF.md
# Halt Sequencer with Oscillator Stabilisation Delay

This block controls the deepest low-power state of a small 8-bit microcontroller. When the CPU decodes a halt instruction, the block decides between three outcomes: ignore it, raise a watchdog reset, or stop the part. Stopping the part means switching off the main oscillator and gating the CPU and peripheral clocks. While the part is stopped, only a wake-capable interrupt or a reset request can restart it. The block then turns the oscillator back on and holds the CPU through a stabilisation delay. Once the delay ends, it tells the CPU whether to fetch the reset vector or to service the interrupt that woke it.

The block has three states:
- `ST_RUN` (encoding 0): normal operation.
- `ST_HALT` (encoding 1): the part is stopped.
- `ST_WAKE` (encoding 2): the stabilisation delay is running.

It has five transitions:
- RUN to HALT, named *enter*.
- HALT to WAKE, named *wake-by-interrupt* or *wake-by-reset*.
- WAKE to WAKE, named *restart*, taken on a reset request during the delay.
- WAKE to RUN, named *resume*.
- RUN to WAKE, named *reset-in-run*.

A watchdog-reset outcome leaves the state at RUN. The input `clk` stands for the main oscillator clock. The delay counter advances only in `ST_WAKE`, which is when that oscillator is running again.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `osc_irq_en` is 1, a `halt_insn` strobe leaves `state` at RUN and raises no `wdg_rst`.
- R2: With `osc_irq_en`=0, `wdg_en`=1 and `wdg_halt_opt`=0, a `halt_insn` strobe gives a one-cycle `wdg_rst` pulse in the next cycle, and `state` stays RUN.
- R3: With `osc_irq_en`=0 and either `wdg_en`=0 or `wdg_halt_opt`=1, a `halt_insn` strobe puts `state` at HALT (1) in the next cycle.
- R4: In the first HALT cycle, `imask_force` is 1 for exactly one cycle and `imask_val` is 2'b10. Otherwise `imask_force` is 0.
- R5: If `wake_irq` is already high when halt is entered, the block spends exactly one cycle in HALT and then moves to WAKE.
- R6: In RUN, `osc_en`, `cpu_clk_en` and `per_clk_en` are all 1. In HALT, all three are 0.
- R7: In HALT, `other_irq` has no effect, and the state stays HALT.
- R8: In WAKE (2), `osc_en`=1, `cpu_clk_en`=0 and `per_clk_en`=1. WAKE lasts 256 cycles when `long_delay` was 0 at the wake edge, and 4096 cycles when it was 1. The count starts from zero.
- R9: On the first RUN cycle after WAKE, `resume` is high for one cycle. `resume_is_reset` is then 1 if the last cause was a reset request and 0 if it was an interrupt.
- R10: `reset_req` takes priority over `wake_irq` in HALT. In WAKE, it restarts the full delay. In RUN, it starts a delay. In every case the resume reason becomes reset.
- R11: After `rst_n` is deasserted, `state` is RUN (0), with `resume`, `wdg_rst` and `imask_force` low.
- R12: `halt_insn` is ignored outside RUN, and it does not alter the delay length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| halt_insn | input | 1 | One-cycle strobe: halt instruction decoded |
| osc_irq_en | input | 1 | Status bit; 1 forbids halt |
| wdg_en | input | 1 | Watchdog is enabled |
| wdg_halt_opt | input | 1 | Option bit; 0 turns halt into a watchdog reset when the watchdog is on |
| long_delay | input | 1 | Selects the 4096-cycle delay (1) or the 256-cycle delay (0) |
| wake_irq | input | 1 | Wake-capable interrupt request |
| other_irq | input | 1 | Interrupt request that cannot wake the part |
| reset_req | input | 1 | Reset request (pin or supervisor) |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| imask_force | output | 1 | Overwrite the interrupt-mask bits this cycle |
| imask_val | output | 2 | Value for the interrupt-mask bits |
| wdg_rst | output | 1 | Watchdog reset request pulse |
| resume | output | 1 | CPU may proceed (one-cycle pulse) |
| resume_is_reset | output | 1 | Resume cause: 1 = fetch reset vector, 0 = service interrupt |
| state | output | 2 | Sequencer state: 0 RUN, 1 HALT, 2 WAKE |

## Verification
The bench provokes two collisions. The first is a reset request and a wake-capable interrupt arriving in the same HALT cycle. The bench checks that the block enters WAKE and resumes with the reset cause. The second is a reset request landing in the middle of the stabilisation delay. The bench judges this by counting WAKE cycles from the restart edge: the count must be the full delay, not the remainder. A halt strobe held during the delay also collides with the running counter, and the bench checks that the remaining length is unchanged.

// File: rtl/halt_pkg.sv
package halt_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_WAKE = 2'd2
    } hstate_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_HALT = 2'd1,
        ACT_WDG  = 2'd2
    } halt_act_e;

    localparam logic [1:0] IMASK_ON_HALT = 2'b10;

endpackage

// File: rtl/halt_entry_decode.sv
module halt_entry_decode
    import halt_pkg::*;
(
    input  logic      halt_insn,
    input  logic      osc_irq_en,
    input  logic      wdg_en,
    input  logic      wdg_halt_opt,
    output halt_act_e act
);

    always_comb begin
        act = ACT_NONE;
        if (halt_insn && !osc_irq_en) begin
            if (wdg_en && !wdg_halt_opt) begin
                act = ACT_WDG;
            end else begin
                act = ACT_HALT;
            end
        end
    end

endmodule

// File: rtl/stab_counter.sv
module stab_counter #(
    parameter int SHORT_CYC = 256,
    parameter int LONG_CYC  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic long_sel,
    output logic done
);

    localparam int CNT_W = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             sel_q;
    logic [CNT_W-1:0] last;

    assign last = sel_q ? LONG_LAST : SHORT_LAST;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= '0;
            sel_q <= long_sel;
        end else if (run && cnt_q != last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && !restart && (cnt_q == last);

    // R10
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= last));

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import halt_pkg::*;
#(
    parameter int SHORT_CYC = 256,
    parameter int LONG_CYC  = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_insn,
    input  logic       osc_irq_en,
    input  logic       wdg_en,
    input  logic       wdg_halt_opt,
    input  logic       long_delay,
    input  logic       wake_irq,
    input  logic       other_irq,
    input  logic       reset_req,
    output logic       osc_en,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       imask_force,
    output logic [1:0] imask_val,
    output logic       wdg_rst,
    output logic       resume,
    output logic       resume_is_reset,
    output logic [1:0] state
);

    hstate_e   st_q, st_n;
    halt_act_e act;
    logic      start_wd;
    logic      dly_done;
    logic      reason_q, reason_n;
    logic      wdg_q, wdg_n;
    logic      force_q, force_n;
    logic      resume_q, resume_n;

    halt_entry_decode u_decode (
        .halt_insn    (halt_insn),
        .osc_irq_en   (osc_irq_en),
        .wdg_en       (wdg_en),
        .wdg_halt_opt (wdg_halt_opt),
        .act          (act)
    );

    stab_counter #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_stab (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q == ST_WAKE),
        .restart  (start_wd),
        .long_sel (long_delay),
        .done     (dly_done)
    );

    // next-state and event decisions
    always_comb begin
        st_n     = st_q;
        start_wd = 1'b0;
        reason_n = reason_q;
        wdg_n    = 1'b0;
        force_n  = 1'b0;
        resume_n = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (reset_req) begin
                    st_n     = ST_WAKE;
                    start_wd = 1'b1;
                    reason_n = 1'b1;
                end else if (act == ACT_WDG) begin
                    wdg_n = 1'b1;
                end else if (act == ACT_HALT) begin
                    st_n    = ST_HALT;
                    force_n = 1'b1;
                end
            end
            ST_HALT: begin
                if (reset_req) begin
                    st_n     = ST_WAKE;
                    start_wd = 1'b1;
                    reason_n = 1'b1;
                end else if (wake_irq) begin
                    st_n     = ST_WAKE;
                    start_wd = 1'b1;
                    reason_n = 1'b0;
                end
            end
            ST_WAKE: begin
                if (reset_req) begin
                    start_wd = 1'b1;
                    reason_n = 1'b1;
                end else if (dly_done) begin
                    st_n     = ST_RUN;
                    resume_n = 1'b1;
                end
            end
            default: begin
                st_n = ST_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_RUN;
            reason_q <= 1'b0;
            wdg_q    <= 1'b0;
            force_q  <= 1'b0;
            resume_q <= 1'b0;
        end else begin
            st_q     <= st_n;
            reason_q <= reason_n;
            wdg_q    <= wdg_n;
            force_q  <= force_n;
            resume_q <= resume_n;
        end
    end

    // outputs
    always_comb begin
        osc_en     = 1'b1;
        cpu_clk_en = 1'b0;
        per_clk_en = 1'b1;
        unique case (st_q)
            ST_RUN: begin
                cpu_clk_en = 1'b1;
            end
            ST_HALT: begin
                osc_en     = 1'b0;
                per_clk_en = 1'b0;
            end
            ST_WAKE: begin
                cpu_clk_en = 1'b0;
            end
            default: begin
                cpu_clk_en = 1'b0;
            end
        endcase
        imask_force     = force_q;
        imask_val       = force_q ? IMASK_ON_HALT : 2'b00;
        wdg_rst         = wdg_q;
        resume          = resume_q;
        resume_is_reset = reason_q;
        state           = st_q;
    end

    // R1
    halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && $past(st_q) == ST_RUN) |-> $past(halt_insn && !osc_irq_en));

    // R2
    wdg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst |-> $past(halt_insn && wdg_en && !wdg_halt_opt && st_q == ST_RUN));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && !wake_irq && !reset_req) |=> (st_q == ST_HALT));

    // R9
    resume_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> ($past(st_q) == ST_WAKE && st_q == ST_RUN));

    // R10
    reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && reset_req) |=> (st_q == ST_WAKE && resume_is_reset));

endmodule

// File: tb/halt_wake_ctrl_test.sv
module halt_wake_ctrl_test;

    localparam int SHORT = 256;
    localparam int LONG  = 4096;

    logic       clk = 1'b0;
    logic       rst_n, halt_insn, osc_irq_en, wdg_en, wdg_halt_opt;
    logic       long_delay, wake_irq, other_irq, reset_req;
    logic       osc_en, cpu_clk_en, per_clk_en, imask_force, wdg_rst;
    logic       resume, resume_is_reset;
    logic [1:0] imask_val, state;

    int  checks = 0;
    int  fails  = 0;
    bit  ended  = 1'b0;

    always #2 clk = ~clk;

    halt_wake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .halt_insn(halt_insn), .osc_irq_en(osc_irq_en),
        .wdg_en(wdg_en), .wdg_halt_opt(wdg_halt_opt), .long_delay(long_delay),
        .wake_irq(wake_irq), .other_irq(other_irq), .reset_req(reset_req),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .imask_force(imask_force), .imask_val(imask_val), .wdg_rst(wdg_rst),
        .resume(resume), .resume_is_reset(resume_is_reset), .state(state)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_halt();
        osc_irq_en = 1'b0; wdg_en = 1'b0; halt_insn = 1'b1;
        step();
        halt_insn = 1'b0;
    endtask

    task automatic do_wake();
        wake_irq = 1'b1;
        step();
        wake_irq = 1'b0;
    endtask

    task automatic wait_delay(int lim, int rsn, string req);
        int n = 0;
        while (state == 2'd2 && n < lim + 10) begin
            n++;
            step();
        end
        chk(req, "delay length", n, lim);
        chk("R9", "resume at first run cycle", resume, 1);
        chk("R9", "resume reason", resume_is_reset, rsn);
        chk("R9", "state after delay", state, 0);
        step();
        chk("R9", "resume width", resume, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; halt_insn = 1'b0; osc_irq_en = 1'b0; wdg_en = 1'b0;
        wdg_halt_opt = 1'b0; long_delay = 1'b0; wake_irq = 1'b0;
        other_irq = 1'b0; reset_req = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R11 reset state, R6 run clocks
        chk("R11", "state", state, 0);
        chk("R11", "resume", resume, 0);
        chk("R11", "wdg_rst", wdg_rst, 0);
        chk("R11", "imask_force", imask_force, 0);
        chk("R6", "run osc_en", osc_en, 1);
        chk("R6", "run cpu_clk_en", cpu_clk_en, 1);
        chk("R6", "run per_clk_en", per_clk_en, 1);

        // sweep every combination of gate bits and pending wake interrupt
        for (int c = 0; c < 16; c++) begin
            bit oi, we, op, wk;
            oi = c[0]; we = c[1]; op = c[2]; wk = c[3];
            osc_irq_en = oi; wdg_en = we; wdg_halt_opt = op; wake_irq = wk;
            halt_insn = 1'b1;
            step();
            halt_insn = 1'b0;
            if (oi) begin
                chk("R1", "state stays run", state, 0);
                chk("R1", "no wdg_rst", wdg_rst, 0);
                wake_irq = 1'b0;
            end else if (we && !op) begin
                chk("R2", "state stays run", state, 0);
                chk("R2", "wdg_rst pulse", wdg_rst, 1);
                wake_irq = 1'b0;
                step();
                chk("R2", "wdg_rst one cycle", wdg_rst, 0);
            end else begin
                chk("R3", "state halt", state, 1);
                chk("R4", "imask_force", imask_force, 1);
                chk("R4", "imask_val", imask_val, 2);
                chk("R6", "halt osc_en", osc_en, 0);
                chk("R6", "halt cpu_clk_en", cpu_clk_en, 0);
                chk("R6", "halt per_clk_en", per_clk_en, 0);
                if (wk) begin
                    step();
                    wake_irq = 1'b0;
                    chk("R5", "immediate wake", state, 2);
                end else begin
                    other_irq = 1'b1; halt_insn = 1'b1;
                    step();
                    chk("R4", "imask_force one cycle", imask_force, 0);
                    chk("R7", "other_irq ignored", state, 1);
                    other_irq = 1'b0; halt_insn = 1'b0;
                    do_wake();
                    chk("R8", "wake state", state, 2);
                end
                chk("R8", "wake osc_en", osc_en, 1);
                chk("R8", "wake cpu_clk_en", cpu_clk_en, 0);
                chk("R8", "wake per_clk_en", per_clk_en, 1);
                wait_delay(SHORT, 0, "R8");
            end
        end
        osc_irq_en = 1'b0; wdg_en = 1'b0; wdg_halt_opt = 1'b0; wake_irq = 1'b0;

        // R8 long delay
        long_delay = 1'b1;
        do_halt();
        do_wake();
        long_delay = 1'b0;
        wait_delay(LONG, 0, "R8");

        // R10 reset during delay restarts the full count
        do_halt();
        do_wake();
        repeat (100) step();
        reset_req = 1'b1;
        step();
        reset_req = 1'b0;
        chk("R10", "still waking", state, 2);
        wait_delay(SHORT, 1, "R10");

        // R10 reset and wake in the same halt cycle
        do_halt();
        reset_req = 1'b1; wake_irq = 1'b1;
        step();
        reset_req = 1'b0; wake_irq = 1'b0;
        chk("R10", "wake state", state, 2);
        chk("R10", "reason reset", resume_is_reset, 1);
        wait_delay(SHORT, 1, "R10");

        // R10 reset request in run
        reset_req = 1'b1;
        step();
        reset_req = 1'b0;
        chk("R10", "run reset enters wake", state, 2);
        wait_delay(SHORT, 1, "R10");

        // R12 halt strobe during the delay is ignored
        do_halt();
        do_wake();
        halt_insn = 1'b1;
        repeat (50) step();
        halt_insn = 1'b0;
        chk("R12", "state stays wake", state, 2);
        wait_delay(SHORT - 50, 0, "R12");

        finish_run();
    end

endmodule